// File: doc/BRIEF.md
# TCM External Error Response Handler

This block sits between the response side of a group of tightly coupled memory ports and the processor's exception logic. The external RAM controller on each port can flag an error and, for reads, can ask for the access to be reissued. In the cycle when a port's read data or write response is valid, the handler samples these flags. It then sorts the event into one of several outcomes: ignore, retry, a synchronous instruction or data abort, a pending asynchronous abort, or an error response returned to a bus slave access. The sort depends on the access source and the access direction.

Each port has its own enable bit. The reset value of that bit comes from a strap input, so checking can be active as soon as reset is released. Software can rewrite the bits afterwards through a simple write strobe. Each abort also updates a fault status record. The record holds a parity-type code that tells a synchronous fault from an asynchronous one, together with the index of the port that caused it. All outputs are registered and appear one cycle after the response that causes them.

Top module: `tcm_xerr_handler`

## Requirements
- R1: When `cfg_we_i` is high at a clock edge, `en_o` takes the value of `cfg_en_i` from the next cycle onwards. Classification in that same cycle still uses the old enable bits.
- R2: While reset is active and straight after it, `en_o` equals `strap_en_i`. All other outputs are zero and `fsr_code_o` is 0.
- R3: When a port's enable bit is clear, its error and retry flags cause no retry, no abort, no bus error and no status update.
- R4: A read (`rsp_write_i`=0) from the instruction side (source 2'b00) or the data side (source 2'b01) that has retry set pulses `retry_o` for that port one cycle later. No abort follows, and retry wins over a simultaneous error.
- R5: A data-side write (source 2'b01, `rsp_write_i`=1) with error set raises `async_pend_o` one cycle later. This happens whether or not retry is set.
- R6: An instruction-side read with error set pulses `iabort_o` one cycle later, and a data-side read with error set pulses `dabort_o` one cycle later. An instruction-side write with error set is ignored.
- R7: An error on a bus slave access (source 2'b10, read or write) pulses `bus_err_o` for that port one cycle later and raises no abort. Retry is not honoured for this source. Source 2'b11 is always ignored.
- R8: `async_pend_o` stays high until `async_ack_i` is sampled high. A new asynchronous event in the acknowledge cycle keeps it high.
- R9: On each abort, `fsr_valid_o` pulses and `fsr_code_o` becomes 5'h19 for a synchronous fault or 5'h18 for an asynchronous one. The code and the port index hold until the next abort.
- R10: When several ports abort in the same cycle, the status record reports the lowest-indexed port.
- R11: The error and retry flags have no effect in a cycle where `rsp_valid_i` for that port is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| strap_en_i | input | NPORTS | Reset value of the per-port enable bits |
| cfg_we_i | input | 1 | Write strobe for the enable register |
| cfg_en_i | input | NPORTS | New enable bits |
| en_o | output | NPORTS | Current enable bits |
| rsp_valid_i | input | NPORTS | Read data or write response valid, per port |
| rsp_write_i | input | NPORTS | Access is a write, per port |
| rsp_src_i | input | 2*NPORTS | Access source per port: 00 instruction, 01 data, 10 bus slave, 11 none |
| rsp_err_i | input | NPORTS | External error flag, per port |
| rsp_retry_i | input | NPORTS | External retry request, per port |
| retry_o | output | NPORTS | Reissue request pulse, per port |
| bus_err_o | output | NPORTS | Bus slave error response pulse, per port |
| iabort_o | output | 1 | Synchronous instruction abort pulse |
| dabort_o | output | 1 | Synchronous data abort pulse |
| async_pend_o | output | 1 | Sticky asynchronous abort pending |
| async_ack_i | input | 1 | Clears the pending asynchronous abort |
| fsr_valid_o | output | 1 | Status record updated this cycle |
| fsr_code_o | output | 5 | Fault code: 5'h19 synchronous, 5'h18 asynchronous |
| fsr_port_o | output | PORT_W | Index of the reporting port |

## Verification
Random stimulus sweeps every mix of source, direction, error, retry and valid across all ports at once. This shows whether the classifier keeps the five outcomes apart and whether retry correctly wins only for instruction-side and data-side reads. Directed cases cover the remaining corners. A disabled port with both flags set separates "ignored" from "classified". An acknowledge that lands in the same cycle as a new data write error separates merging from losing the event. Simultaneous aborts on two ports expose the status priority, and an enable write alongside an error shows which enable value is used.

// File: rtl/tcm_xerr_pkg.sv
package tcm_xerr_pkg;

  typedef enum logic [1:0] {
    SRC_INSTR = 2'b00,
    SRC_DATA  = 2'b01,
    SRC_SLAVE = 2'b10,
    SRC_NONE  = 2'b11
  } src_e;

  typedef enum logic [2:0] {
    CL_NONE   = 3'd0,
    CL_RETRY  = 3'd1,
    CL_IABT   = 3'd2,
    CL_DABT   = 3'd3,
    CL_ASYNC  = 3'd4,
    CL_BUSERR = 3'd5
  } xclass_e;

  localparam logic [4:0] FSR_SYNC_PAR  = 5'h19;
  localparam logic [4:0] FSR_ASYNC_PAR = 5'h18;

  // Sorts one sampled response into its outcome.
  function automatic xclass_e xerr_classify(input logic valid, input logic en,
                                            input logic err, input logic retry,
                                            input logic [1:0] src, input logic wr);
    xclass_e c;
    c = CL_NONE;
    if (valid && en) begin
      if (!wr && retry && (src == SRC_INSTR || src == SRC_DATA)) begin
        c = CL_RETRY;
      end else if (err) begin
        case (src)
          SRC_INSTR: c = wr ? CL_NONE : CL_IABT;
          SRC_DATA:  c = wr ? CL_ASYNC : CL_DABT;
          SRC_SLAVE: c = CL_BUSERR;
          default:   c = CL_NONE;
        endcase
      end
    end
    return c;
  endfunction

  function automatic logic is_abort(input xclass_e c);
    return (c == CL_IABT) || (c == CL_DABT) || (c == CL_ASYNC);
  endfunction

endpackage

// File: rtl/tcm_xerr_enreg.sv
module tcm_xerr_enreg #(
  parameter int NPORTS = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NPORTS-1:0] strap_en_i,
  input  logic              we_i,
  input  logic [NPORTS-1:0] wdata_i,
  output logic [NPORTS-1:0] en_o
);

  logic [NPORTS-1:0] en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= strap_en_i;
    end else if (we_i) begin
      en_q <= wdata_i;
    end
  end

  assign en_o = en_q;

  // R1: a write lands in the register on the following cycle
  a_r1_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (en_q == $past(wdata_i)));

  a_r1_hold_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(en_q));

endmodule

// File: rtl/tcm_xerr_classify.sv
module tcm_xerr_classify
  import tcm_xerr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       valid_i,
  input  logic       en_i,
  input  logic       err_i,
  input  logic       retry_i,
  input  logic [1:0] src_i,
  input  logic       wr_i,
  output xclass_e    cls_o,
  output logic       retry_q_o,
  output logic       buserr_q_o
);

  xclass_e cls_d;
  logic    retry_q, buserr_q;

  always_comb begin
    cls_d = xerr_classify(valid_i, en_i, err_i, retry_i, src_i, wr_i);
  end

  assign cls_o = cls_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      retry_q  <= 1'b0;
      buserr_q <= 1'b0;
    end else begin
      retry_q  <= (cls_d == CL_RETRY);
      buserr_q <= (cls_d == CL_BUSERR);
    end
  end

  assign retry_q_o  = retry_q;
  assign buserr_q_o = buserr_q;

  // R11: no valid, no response of any kind
  a_r11_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!retry_q && !buserr_q));

  // R3: disabled port produces nothing
  a_r3_disabled_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!retry_q && !buserr_q));

  // R4: retry never from a write
  a_r4_retry_read_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && wr_i) |=> !retry_q);

  // R7: bus error pulse only for slave-sourced accesses
  a_r7_buserr_slave: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buserr_q |-> ($past(src_i) == SRC_SLAVE));

endmodule

// File: rtl/tcm_xerr_async.sv
module tcm_xerr_async (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic ack_i,
  output logic pend_o
);

  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
    end else if (set_i) begin
      pend_q <= 1'b1;
    end else if (ack_i) begin
      pend_q <= 1'b0;
    end
  end

  assign pend_o = pend_q;

  // R8: stays set until acknowledged
  a_r8_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !ack_i) |=> pend_q);

  // R8: a new event beats the acknowledge
  a_r8_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> pend_q);

endmodule

// File: rtl/tcm_xerr_fsr.sv
module tcm_xerr_fsr
  import tcm_xerr_pkg::*;
#(
  parameter int NPORTS = 3,
  parameter int PORT_W = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  xclass_e           cls_i [NPORTS],
  output logic              valid_o,
  output logic [4:0]        code_o,
  output logic [PORT_W-1:0] port_o
);

  logic              hit;
  logic              hit_async;
  logic [PORT_W-1:0] hit_port;
  logic              valid_q;
  logic [4:0]        code_q;
  logic [PORT_W-1:0] port_q;

  // Lowest index wins: scan downwards so the last match is the smallest.
  always_comb begin
    hit       = 1'b0;
    hit_async = 1'b0;
    hit_port  = '0;
    for (int i = NPORTS - 1; i >= 0; i--) begin
      if (is_abort(cls_i[i])) begin
        hit       = 1'b1;
        hit_async = (cls_i[i] == CL_ASYNC);
        hit_port  = PORT_W'(i);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      code_q  <= '0;
      port_q  <= '0;
    end else begin
      valid_q <= hit;
      if (hit) begin
        code_q <= hit_async ? FSR_ASYNC_PAR : FSR_SYNC_PAR;
        port_q <= hit_port;
      end
    end
  end

  assign valid_o = valid_q;
  assign code_o  = code_q;
  assign port_o  = port_q;

  // R9: a recorded fault carries one of the two parity-type codes
  a_r9_code_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |-> (code_q == FSR_SYNC_PAR || code_q == FSR_ASYNC_PAR));

  // R9: record holds between faults
  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit |=> ($stable(code_q) && $stable(port_q)));

  // R10: reported port had an abort in the sampling cycle
  a_r10_port_aborted: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |=> is_abort($past(cls_i[hit_port])));

endmodule

// File: rtl/tcm_xerr_handler.sv
module tcm_xerr_handler
  import tcm_xerr_pkg::*;
#(
  parameter int NPORTS = 3,
  parameter int PORT_W = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NPORTS-1:0]   strap_en_i,
  input  logic                cfg_we_i,
  input  logic [NPORTS-1:0]   cfg_en_i,
  output logic [NPORTS-1:0]   en_o,
  input  logic [NPORTS-1:0]   rsp_valid_i,
  input  logic [NPORTS-1:0]   rsp_write_i,
  input  logic [2*NPORTS-1:0] rsp_src_i,
  input  logic [NPORTS-1:0]   rsp_err_i,
  input  logic [NPORTS-1:0]   rsp_retry_i,
  output logic [NPORTS-1:0]   retry_o,
  output logic [NPORTS-1:0]   bus_err_o,
  output logic                iabort_o,
  output logic                dabort_o,
  output logic                async_pend_o,
  input  logic                async_ack_i,
  output logic                fsr_valid_o,
  output logic [4:0]          fsr_code_o,
  output logic [PORT_W-1:0]   fsr_port_o
);

  logic [NPORTS-1:0] en_q;
  xclass_e           cls [NPORTS];
  logic [NPORTS-1:0] is_iabt, is_dabt, is_async;
  logic              any_iabt, any_dabt, any_async;
  logic              iabt_q, dabt_q;

  tcm_xerr_enreg #(.NPORTS(NPORTS)) u_enreg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .strap_en_i (strap_en_i),
    .we_i       (cfg_we_i),
    .wdata_i    (cfg_en_i),
    .en_o       (en_q)
  );

  assign en_o = en_q;

  for (genvar g = 0; g < NPORTS; g++) begin : g_port
    tcm_xerr_classify u_cls (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .valid_i    (rsp_valid_i[g]),
      .en_i       (en_q[g]),
      .err_i      (rsp_err_i[g]),
      .retry_i    (rsp_retry_i[g]),
      .src_i      (rsp_src_i[2*g +: 2]),
      .wr_i       (rsp_write_i[g]),
      .cls_o      (cls[g]),
      .retry_q_o  (retry_o[g]),
      .buserr_q_o (bus_err_o[g])
    );

    assign is_iabt[g]  = (cls[g] == CL_IABT);
    assign is_dabt[g]  = (cls[g] == CL_DABT);
    assign is_async[g] = (cls[g] == CL_ASYNC);

    // R4: a retried read never produces a bus error on the same port
    a_r4_retry_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(retry_o[g] && bus_err_o[g]));

    // R3: a disabled port cannot raise the pending flag on its own
    a_r3_no_async_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!en_q[g] && !async_pend_o && (rsp_valid_i & en_q) == '0) |=> !async_pend_o);
  end

  assign any_iabt  = |is_iabt;
  assign any_dabt  = |is_dabt;
  assign any_async = |is_async;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      iabt_q <= 1'b0;
      dabt_q <= 1'b0;
    end else begin
      iabt_q <= any_iabt;
      dabt_q <= any_dabt;
    end
  end

  assign iabort_o = iabt_q;
  assign dabort_o = dabt_q;

  tcm_xerr_async u_async (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (any_async),
    .ack_i  (async_ack_i),
    .pend_o (async_pend_o)
  );

  tcm_xerr_fsr #(.NPORTS(NPORTS), .PORT_W(PORT_W)) u_fsr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cls_i   (cls),
    .valid_o (fsr_valid_o),
    .code_o  (fsr_code_o),
    .port_o  (fsr_port_o)
  );

  // R6: every synchronous abort is accompanied by a status update
  a_r6_abort_logged: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iabort_o || dabort_o) |-> fsr_valid_o);

  // R7: slave errors alone never abort the processor
  a_r7_no_abort_slave: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_err_o != '0 && !fsr_valid_o) |-> (!iabort_o && !dabort_o));

endmodule

// File: tb/tcm_xerr_handler_tb_top.sv
module tcm_xerr_handler_tb_top;
  localparam int NP = 3;
  localparam int PW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [NP-1:0]   strap, cfg_en, en, valid, wr, err, rty, retry_o, buserr_o;
  logic [2*NP-1:0] src;
  logic            cfg_we, ack, iabt, dabt, apend, fval;
  logic [4:0]      fcode;
  logic [PW-1:0]   fport;

  tcm_xerr_handler #(.NPORTS(NP)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .strap_en_i(strap), .cfg_we_i(cfg_we),
    .cfg_en_i(cfg_en), .en_o(en), .rsp_valid_i(valid), .rsp_write_i(wr),
    .rsp_src_i(src), .rsp_err_i(err), .rsp_retry_i(rty), .retry_o(retry_o),
    .bus_err_o(buserr_o), .iabort_o(iabt), .dabort_o(dabt),
    .async_pend_o(apend), .async_ack_i(ack), .fsr_valid_o(fval),
    .fsr_code_o(fcode), .fsr_port_o(fport)
  );

  int n_chk = 0, n_fail = 0;

  // bench model state
  logic [NP-1:0] m_en;
  logic          m_pend;
  logic [4:0]    m_code;
  logic [PW-1:0] m_port;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // 0 none,1 retry,2 iabt,3 dabt,4 async,5 buserr  (nested by source first)
  function automatic int outcome(input logic v, input logic e, input logic er,
                                 input logic rt, input logic [1:0] s, input logic w);
    if (!(v && e)) return 0;
    if (s == 2'b10) return er ? 5 : 0;
    if (s == 2'b11) return 0;
    if (s == 2'b00) begin
      if (w) return 0;
      if (rt) return 1;
      return er ? 2 : 0;
    end
    if (w) return er ? 4 : 0;
    if (rt) return 1;
    return er ? 3 : 0;
  endfunction

  // One cycle: inputs already driven; predict, clock, compare.
  task automatic step();
    logic [NP-1:0] x_rty, x_bus;
    logic x_i, x_d, x_a, x_fv;
    logic [4:0] x_code;
    logic [PW-1:0] x_port;
    x_rty = '0; x_bus = '0; x_i = 0; x_d = 0; x_a = 0; x_fv = 0;
    x_code = m_code; x_port = m_port;
    for (int p = 0; p < NP; p++) begin
      int o;
      o = outcome(valid[p], m_en[p], err[p], rty[p], src[2*p +: 2], wr[p]);
      x_rty[p] = (o == 1);
      x_bus[p] = (o == 5);
      if (o == 2) x_i = 1;
      if (o == 3) x_d = 1;
      if (o == 4) x_a = 1;
      if (o >= 2 && o <= 4 && !x_fv) begin
        x_fv = 1; x_port = PW'(p);
        x_code = (o == 4) ? 5'h18 : 5'h19;
      end
    end
    m_pend = x_a ? 1'b1 : (ack ? 1'b0 : m_pend);
    if (cfg_we) m_en = cfg_en;
    m_code = x_code; m_port = x_port;
    @(posedge clk); @(negedge clk);
    chk("R4 retry_o", 32'(retry_o), 32'(x_rty));
    chk("R7 bus_err_o", 32'(buserr_o), 32'(x_bus));
    chk("R6 iabort_o", 32'(iabt), 32'(x_i));
    chk("R6 dabort_o", 32'(dabt), 32'(x_d));
    chk("R5/R8 async_pend_o", 32'(apend), 32'(m_pend));
    chk("R9 fsr_valid_o", 32'(fval), 32'(x_fv));
    chk("R9 fsr_code_o", 32'(fcode), 32'(m_code));
    chk("R10 fsr_port_o", 32'(fport), 32'(m_port));
    chk("R1 en_o", 32'(en), 32'(m_en));
  endtask

  task automatic idle();
    valid = '0; wr = '0; err = '0; rty = '0; src = '0; cfg_we = 0; ack = 0; cfg_en = '0;
  endtask

  task automatic drv(input int p, input logic [1:0] s, input logic w,
                     input logic e, input logic r);
    valid[p] = 1; src[2*p +: 2] = s; wr[p] = w; err[p] = e; rty[p] = r;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    int unsigned sd;
    sd = $urandom(32'd4242);
    idle();
    strap = 3'b101;
    m_en = 3'b101; m_pend = 0; m_code = '0; m_port = '0;
    repeat (3) @(negedge clk);
    // R2 reset state
    chk("R2 en_o strap", 32'(en), 32'h5);
    chk("R2 outputs zero", {apend, fval, iabt, dabt, retry_o, buserr_o, fcode}, 32'h0);
    rst_n = 1;
    @(negedge clk);
    chk("R2 en_o after release", 32'(en), 32'h5);

    // R3 disabled port 1 with everything set
    idle(); drv(1, 2'b01, 1, 1, 1); step();
    idle(); drv(1, 2'b10, 0, 1, 0); step();
    chk("R3 disabled port quiet", {apend, fval, buserr_o}, 32'h0);

    // R1 enable all; error alongside write uses old bits
    idle(); cfg_we = 1; cfg_en = 3'b111; drv(1, 2'b01, 0, 1, 0); step();
    chk("R1 old enable used", 32'(dabt), 32'h0);

    // R4 retry beats error on D and I reads
    idle(); drv(0, 2'b01, 0, 1, 1); drv(2, 2'b00, 0, 1, 1); step();
    chk("R4 retry both ports", 32'(retry_o), 32'h5);
    // R7 slave with retry still errors
    idle(); drv(1, 2'b10, 0, 1, 1); step();
    chk("R7 slave retry ignored", 32'(buserr_o), 32'h2);
    // R6 instr write error ignored, source 11 ignored
    idle(); drv(0, 2'b00, 1, 1, 0); drv(1, 2'b11, 0, 1, 1); step();
    chk("R6 instr write ignored", {iabt, fval, retry_o}, 32'h0);
    // R11 flags without valid
    idle(); err = '1; rty = '1; src = 6'b010101; step();
    chk("R11 no valid quiet", {fval, retry_o, buserr_o}, 32'h0);

    // R5/R8 async set, hold, ack+new set merges, then ack clears
    idle(); drv(2, 2'b01, 1, 1, 1); step();
    chk("R5 async pending", 32'(apend), 32'h1);
    chk("R9 async code", 32'(fcode), 32'h18);
    idle(); step(); step();
    chk("R8 sticky", 32'(apend), 32'h1);
    idle(); ack = 1; drv(0, 2'b01, 1, 1, 0); step();
    chk("R8 set wins over ack", 32'(apend), 32'h1);
    idle(); ack = 1; step();
    chk("R8 ack clears", 32'(apend), 32'h0);

    // R10 simultaneous aborts: ports 2 (iabt) and 1 (dabt) -> port 1
    idle(); drv(2, 2'b00, 0, 1, 0); drv(1, 2'b01, 0, 1, 0); step();
    chk("R10 lowest port", 32'(fport), 32'h1);
    chk("R9 sync code", 32'(fcode), 32'h19);
    idle(); step();
    chk("R9 code held", 32'(fcode), 32'h19);

    // random sweep
    for (int k = 0; k < 3000; k++) begin
      idle();
      valid = NP'($urandom); wr = NP'($urandom); err = NP'($urandom);
      rty = NP'($urandom); src = (2*NP)'($urandom);
      ack = ($urandom % 4) == 0;
      cfg_we = ($urandom % 16) == 0; cfg_en = NP'($urandom);
      step();
    end

    idle();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule